// File: doc/BRIEF.md
# Non-Volatile Row Program Sequencer

This block runs the internal programming cycle of a small non-volatile word array that is modelled as a register file. A serial front end reports three events: the first write data byte has arrived, the second write data byte has arrived, and the bus STOP has been seen. Together with the first byte, the front end supplies the row index, the current content of that row, and which half of the word the first byte replaces. The sequencer keeps a 16-bit word buffer and merges the incoming bytes into it. It then runs a timed erase phase followed by a timed write phase, and it drives a one-cycle write strobe, a row index and cell data into the array.

Erase starts on the first data byte, without waiting for STOP. A second byte is merged only while erase is still running. The write phase begins only once erase has finished and STOP has been seen. A fill command erases every row and then sets every row to all ones or all zeros, using the same two timed phases.

States: `ST_IDLE` (no cycle running), `ST_ERASE` (erase phase), `ST_HOLD` (erase finished, waiting for STOP), `ST_WRITE` (write phase), `ST_FILL_ERASE` and `ST_FILL_WRITE` (fill command phases). Transitions:
- IDLE→ERASE on a first byte.
- IDLE→FILL_ERASE on a fill request when no first byte is present.
- ERASE→WRITE at the end of the phase if STOP has been seen, otherwise ERASE→HOLD.
- HOLD→WRITE on STOP.
- WRITE→IDLE at the end of the phase.
- FILL_ERASE→FILL_WRITE at the end of the phase.
- FILL_WRITE→IDLE at the end of the phase.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, `busy` is 0 and `arr_we` is 0.
- R2: A `byte1_valid` pulse while idle starts erase. In the first erase cycle, exactly one array write of all zeros goes to `row_addr`.
- R3: With `hi_first`=1, the first byte lands in bits [15:8] and the second byte in bits [7:0]. With `hi_first`=0 the halves swap. A half that receives no byte keeps its value from `base_word`.
- R4: Count the clock edge that samples the first byte as edge 0. A second byte sampled at edge k is merged only if 1 ≤ k ≤ PHASE_CYCLES. Otherwise it is ignored.
- R5: The write phase starts only after STOP. For STOP sampled at edge s, `busy` stays high for max(s, PHASE_CYCLES) + PHASE_CYCLES cycles. The merged word is written to the row in the first write cycle.
- R6: Each phase lasts exactly PHASE_CYCLES clock cycles.
- R7: `busy` is high from the first erase cycle through the last write cycle. A first byte or a fill request that arrives while busy is ignored.
- R8: A fill request while idle writes zeros to every row during erase, then writes all ones (`fill_ones`=1) or all zeros to every row during write. `busy` lasts 2·PHASE_CYCLES cycles, and no STOP is needed.
- R9: STOP and second-byte pulses while idle cause no array write and leave `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte1_valid | input | 1 | First write data byte received |
| row_addr | input | ROW_W | Row index, sampled with byte1_valid |
| base_word | input | WORD_W | Current content of the addressed row |
| hi_first | input | 1 | 1: first byte is the high half |
| byte1_data | input | WORD_W/2 | First data byte |
| byte2_valid | input | 1 | Second write data byte received |
| byte2_data | input | WORD_W/2 | Second data byte |
| stop_seen | input | 1 | Bus STOP detected |
| fill_req | input | 1 | Fill-all command |
| fill_ones | input | 1 | Fill value: 1 = all ones, 0 = all zeros |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array row write strobe |
| arr_row | output | ROW_W | Array row index |
| arr_wdata | output | WORD_W | Array write data |

## Verification
The bench builds the block with PHASE_CYCLES=20, ROWS=8 and a 16-bit word. With these values, a full erase-plus-write cycle takes a few dozen clock cycles. That short phase puts the erase-window edges within reach: a second byte at exactly edge 20 and at edges 21 and 22, STOP before erase ends, and STOP after it. The eight-row array makes the fill sweep short enough to check every row after both fill values.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_HOLD,
        ST_WRITE,
        ST_FILL_ERASE,
        ST_FILL_WRITE
    } seq_state_t;

endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
    parameter int PHASE_CYCLES = 500000,
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PHASE_CYCLES - 1);

    assign last = (cnt == LAST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_VAL);

endmodule

// File: rtl/nvm_word_buffer.sv
module nvm_word_buffer #(
    parameter int WORD_W = 16,
    localparam int BYTE_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              merge_second,
    input  logic              hi_first,
    input  logic [WORD_W-1:0] base_word,
    input  logic [BYTE_W-1:0] first_byte,
    input  logic [BYTE_W-1:0] second_byte,
    output logic [WORD_W-1:0] word
);

    logic hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            hi_q <= 1'b0;
        end else if (load_first) begin
            hi_q <= hi_first;
            if (hi_first) begin
                word <= {first_byte, base_word[BYTE_W-1:0]};
            end else begin
                word <= {base_word[WORD_W-1:BYTE_W], first_byte};
            end
        end else if (merge_second) begin
            if (hi_q) begin
                word[BYTE_W-1:0] <= second_byte;
            end else begin
                word[WORD_W-1:BYTE_W] <= second_byte;
            end
        end
    end

    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_first || merge_second) |=> $stable(word));

endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
    import nvm_seq_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int WORD_W = 16,
    parameter int PHASE_CYCLES = 500000,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte1_valid,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic              byte2_valid,
    input  logic              stop_seen,
    input  logic              fill_req,
    input  logic              fill_ones,
    input  logic [CNT_W-1:0]  tmr_cnt,
    input  logic              tmr_last,
    input  logic [WORD_W-1:0] word,
    output logic              tmr_clr,
    output logic              ld_first,
    output logic              ld_second,
    output logic              busy,
    output logic              arr_we,
    output logic [ROW_W-1:0]  arr_row,
    output logic [WORD_W-1:0] arr_wdata
);

    localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(ROWS);

    seq_state_t state, state_nx;
    logic             stop_flag;
    logic [ROW_W-1:0] row_q;
    logic             fill_val_q;
    logic             sweep_on;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (byte1_valid) begin
                    state_nx = ST_ERASE;
                end else if (fill_req) begin
                    state_nx = ST_FILL_ERASE;
                end
            end
            ST_ERASE: begin
                if (tmr_last) begin
                    state_nx = (stop_flag || stop_seen) ? ST_WRITE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (stop_seen) begin
                    state_nx = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (tmr_last) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_FILL_ERASE: begin
                if (tmr_last) begin
                    state_nx = ST_FILL_WRITE;
                end
            end
            ST_FILL_WRITE: begin
                if (tmr_last) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign tmr_clr   = (state_nx != state);
    assign ld_first  = (state == ST_IDLE) && byte1_valid;
    assign ld_second = (state == ST_ERASE) && byte2_valid;

    // state register and per-command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            stop_flag  <= 1'b0;
            row_q      <= '0;
            fill_val_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state != ST_ERASE) begin
                stop_flag <= 1'b0;
            end else if (stop_seen) begin
                stop_flag <= 1'b1;
            end
            if (ld_first) begin
                row_q <= row_addr;
            end
            if ((state == ST_IDLE) && !byte1_valid && fill_req) begin
                fill_val_q <= fill_ones;
            end
        end
    end

    assign sweep_on = (tmr_cnt < SWEEP_END);

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        arr_we    = 1'b0;
        arr_row   = row_q;
        arr_wdata = '0;
        unique case (state)
            ST_IDLE, ST_HOLD: begin
                arr_we = 1'b0;
            end
            ST_ERASE: begin
                arr_we = (tmr_cnt == '0);
            end
            ST_WRITE: begin
                arr_we    = (tmr_cnt == '0);
                arr_wdata = word;
            end
            ST_FILL_ERASE: begin
                arr_we  = sweep_on;
                arr_row = tmr_cnt[ROW_W-1:0];
            end
            ST_FILL_WRITE: begin
                arr_we    = sweep_on;
                arr_row   = tmr_cnt[ROW_W-1:0];
                arr_wdata = {WORD_W{fill_val_q}};
            end
            default: arr_we = 1'b0;
        endcase
    end

    // R1
    write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(byte1_valid || fill_req));

    // R5
    write_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && $past(state) != ST_WRITE) |-> $past(stop_seen || stop_flag));

    // R2
    erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && (state == ST_ERASE || state == ST_FILL_ERASE)) |-> (arr_wdata == '0));

endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq #(
    parameter int ROWS = 32,
    parameter int WORD_W = 16,
    parameter int PHASE_CYCLES = 500000,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int BYTE_W = WORD_W / 2,
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte1_valid,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [WORD_W-1:0] base_word,
    input  logic              hi_first,
    input  logic [BYTE_W-1:0] byte1_data,
    input  logic              byte2_valid,
    input  logic [BYTE_W-1:0] byte2_data,
    input  logic              stop_seen,
    input  logic              fill_req,
    input  logic              fill_ones,
    output logic              busy,
    output logic              arr_we,
    output logic [ROW_W-1:0]  arr_row,
    output logic [WORD_W-1:0] arr_wdata
);

    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_last;
    logic              tmr_clr;
    logic              ld_first;
    logic              ld_second;
    logic [WORD_W-1:0] word;

    initial begin
        phase_len_chk: assert (PHASE_CYCLES > ROWS && ROWS > 1)
            else $error("phase length must exceed the row count");
    end

    nvm_phase_timer #(
        .PHASE_CYCLES(PHASE_CYCLES)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .cnt  (tmr_cnt),
        .last (tmr_last)
    );

    nvm_word_buffer #(
        .WORD_W(WORD_W)
    ) buffer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_first  (ld_first),
        .merge_second(ld_second),
        .hi_first    (hi_first),
        .base_word   (base_word),
        .first_byte  (byte1_data),
        .second_byte (byte2_data),
        .word        (word)
    );

    nvm_seq_ctrl #(
        .ROWS        (ROWS),
        .WORD_W      (WORD_W),
        .PHASE_CYCLES(PHASE_CYCLES)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte1_valid(byte1_valid),
        .row_addr   (row_addr),
        .byte2_valid(byte2_valid),
        .stop_seen  (stop_seen),
        .fill_req   (fill_req),
        .fill_ones  (fill_ones),
        .tmr_cnt    (tmr_cnt),
        .tmr_last   (tmr_last),
        .word       (word),
        .tmr_clr    (tmr_clr),
        .ld_first   (ld_first),
        .ld_second  (ld_second),
        .busy       (busy),
        .arr_we     (arr_we),
        .arr_row    (arr_row),
        .arr_wdata  (arr_wdata)
    );

endmodule

// File: tb/nvm_prog_seq_tb.sv
module nvm_prog_seq_tb_top;

    localparam int ROWS = 8;
    localparam int WORD_W = 16;
    localparam int P = 20;
    localparam int ROW_W = 3;

    typedef struct packed {
        logic [2:0]  row;
        logic [15:0] base;
        logic        hi;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [7:0]  k2;   // 0 = no second byte
        logic [7:0]  s;
        logic [15:0] exp_word;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 16'hA5C3, 1'b1, 8'h12, 8'h34, 8'd5,  8'd8,  16'h1234},
        '{3'd5, 16'hA5C3, 1'b0, 8'h12, 8'h34, 8'd5,  8'd25, 16'h3412},
        '{3'd1, 16'hBEEF, 1'b1, 8'h77, 8'h00, 8'd0,  8'd3,  16'h77EF},
        '{3'd6, 16'hBEEF, 1'b0, 8'h77, 8'h99, 8'd20, 8'd20, 16'h9977},
        '{3'd2, 16'h1357, 1'b1, 8'hAA, 8'h55, 8'd21, 8'd30, 16'hAA57},
        '{3'd7, 16'h1357, 1'b0, 8'hAA, 8'h55, 8'd22, 8'd21, 16'h13AA}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              byte1_valid = 1'b0;
    logic [ROW_W-1:0]  row_addr = '0;
    logic [WORD_W-1:0] base_word = '0;
    logic              hi_first = 1'b0;
    logic [7:0]        byte1_data = '0;
    logic              byte2_valid = 1'b0;
    logic [7:0]        byte2_data = '0;
    logic              stop_seen = 1'b0;
    logic              fill_req = 1'b0;
    logic              fill_ones = 1'b0;
    logic              busy;
    logic              arr_we;
    logic [ROW_W-1:0]  arr_row;
    logic [WORD_W-1:0] arr_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [WORD_W-1:0] mem [ROWS];
    int                we_count = 0;
    logic [WORD_W-1:0] first_wd = '0;

    always #5 clk = ~clk;

    nvm_prog_seq #(
        .ROWS(ROWS), .WORD_W(WORD_W), .PHASE_CYCLES(P)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .byte1_valid(byte1_valid), .row_addr(row_addr),
        .base_word(base_word), .hi_first(hi_first), .byte1_data(byte1_data),
        .byte2_valid(byte2_valid), .byte2_data(byte2_data), .stop_seen(stop_seen),
        .fill_req(fill_req), .fill_ones(fill_ones), .busy(busy), .arr_we(arr_we),
        .arr_row(arr_row), .arr_wdata(arr_wdata)
    );

    // array model fed by the write strobe, sampled mid-cycle
    always @(negedge clk) begin
        if (arr_we) begin
            if (we_count == 0) first_wd = arr_wdata;
            mem[arr_row] = arr_wdata;
            we_count = we_count + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int r = 0; r < ROWS; r++) mem[r] = 16'h5A5A;
        we_count = 0;
        first_wd = '0;
    endtask

    // one write command; k2 and s count edges after the first-byte edge
    task automatic run_write(input vec_t v, output int busy_cycles);
        int lim;
        busy_cycles = 0;
        lim = ((int'(v.s) > P) ? int'(v.s) : P) + P + 6;
        @(negedge clk);
        byte1_valid = 1'b1; row_addr = v.row; base_word = v.base;
        hi_first = v.hi; byte1_data = v.b1;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            byte1_valid = 1'b0;
            if (busy) busy_cycles++;
            byte2_valid = (v.k2 != 0) && (k == int'(v.k2));
            byte2_data  = v.b2;
            stop_seen   = (k == int'(v.s));
        end
        byte2_valid = 1'b0; stop_seen = 1'b0;
    endtask

    initial begin
        int bc;
        int lim;
        int exp_busy;
        clear_model();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 arr_we in reset", 32'(arr_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 arr_we after reset", 32'(arr_we), 32'd0);

        // table-driven write commands (R2..R6)
        for (int i = 0; i < NV; i++) begin
            clear_model();
            run_write(VECS[i], bc);
            exp_busy = ((int'(VECS[i].s) > P) ? int'(VECS[i].s) : P) + P;
            check($sformatf("R3/R4 stored word vec%0d", i), 32'(mem[VECS[i].row]), 32'(VECS[i].exp_word));
            check($sformatf("R5/R6 busy length vec%0d", i), bc, exp_busy);
            check($sformatf("R2 erase zero vec%0d", i), 32'(first_wd), 32'd0);
            check($sformatf("R2 write count vec%0d", i), we_count, 2);
            check($sformatf("R7 busy end vec%0d", i), 32'(busy), 32'd0);
        end

        // R7: first byte and fill request during a busy cycle are ignored
        clear_model();
        @(negedge clk);
        byte1_valid = 1'b1; row_addr = 3'd0; base_word = 16'h0000;
        hi_first = 1'b1; byte1_data = 8'hFF;
        for (int k = 1; k <= 2 * P + 8; k++) begin
            @(negedge clk);
            byte1_valid = (k == 3);
            row_addr    = (k == 3) ? 3'd4 : 3'd0;
            base_word   = (k == 3) ? 16'hFFFF : 16'h0000;
            byte1_data  = (k == 3) ? 8'h11 : 8'hFF;
            fill_req    = (k == 4);
            fill_ones   = 1'b1;
            stop_seen   = (k == 5);
        end
        byte1_valid = 1'b0; fill_req = 1'b0; stop_seen = 1'b0;
        check("R7 original row stored", 32'(mem[0]), 32'hFF00);
        check("R7 busy-time first byte ignored", 32'(mem[4]), 32'h5A5A);
        check("R7 busy-time requests no extra writes", we_count, 2);

        // R9: STOP and second byte while idle do nothing
        clear_model();
        @(negedge clk);
        stop_seen = 1'b1; byte2_valid = 1'b1; byte2_data = 8'h66;
        @(negedge clk);
        stop_seen = 1'b0; byte2_valid = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R9 idle busy stays low", 32'(busy), 32'd0);
        end
        check("R9 idle no array write", we_count, 0);

        // R8: fill with ones, then with zeros
        for (int f = 1; f >= 0; f--) begin
            clear_model();
            bc = 0;
            @(negedge clk);
            fill_req = 1'b1; fill_ones = f[0];
            lim = 2 * P + 6;
            for (int k = 1; k <= lim; k++) begin
                @(negedge clk);
                fill_req = 1'b0;
                if (busy) bc++;
            end
            check($sformatf("R8 fill%0d busy length", f), bc, 2 * P);
            check($sformatf("R8 fill%0d write count", f), we_count, 2 * ROWS);
            check($sformatf("R8 fill%0d erase zeros", f), 32'(first_wd), 32'd0);
            for (int r = 0; r < ROWS; r++) begin
                check($sformatf("R8 fill%0d row %0d", f, r), 32'(mem[r]), f ? 32'hFFFF : 32'h0000);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule